// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits beside the decode stage of an in-order pipeline. It watches for operand dependences and stalls an instruction in decode until every source operand can be forwarded. The execute side has four paths of different length: a one-step integer path, a three-step floating-point add/subtract path, a five-step floating-point multiply path and a two-step data-memory path. For each destination register, the block keeps a countdown of the cycles left before the producing path's final stage delivers the result. It also records which path will supply it.

An instruction that leaves decode enters the first step of its path on the next cycle. A consumer may therefore leave decode in the same cycle that its producer sits in the final step, because the final-step output is forwarded into the consumer's first step. While `stall` is high, the surrounding pipeline holds its fetch and decode registers and sends a bubble into execute. The bubble is signalled by `issue` being low. For each operand, `fwd_sel_a` and `fwd_sel_b` name the path whose final-stage output supplies it, or the register file. Register 0 is constant and never creates a dependence.

Top module: `issue_interlock`

## Requirements
- R1: After reset no producer is in flight. Any valid instruction issues in its first decode cycle with both selects at 0 (register file). A reset in mid-run discards every pending dependence.
- R2: A multiply (class code 2) has a latency of 5. A consumer of its destination that reaches decode in the cycle after the multiply issued stalls exactly 4 cycles. It then issues with that operand's select at 3 (multiply path).
- R3: An add/subtract (class code 1) has a latency of 3. An immediately following consumer stalls exactly 2 cycles and issues with select 2 (add path).
- R4: A load (class code 3) has a latency of 2. An immediately following consumer, including a dependent add, stalls exactly 1 cycle and issues with select 4 (memory path).
- R5: An integer operation (class code 0) has a latency of 1. An immediately following consumer does not stall and issues with select 1 (integer path).
- R6: A consumer of two in-flight results stalls until the later of the two becomes forwardable.
- R7: A result can be forwarded in exactly one cycle, the first cycle in which its consumer may issue. In any later cycle the operand's select is 0, because the value is then taken from the register file.
- R8: Register 0 never causes a stall. As a source it always selects 0, even right after an instruction that named it as destination.
- R9: An instruction with its destination-enable low creates no dependence.
- R10: A later instruction writing the same register replaces the earlier producer. Consumers then follow the newer instruction's path and timing.
- R11: `issue` is high exactly when `dec_valid` is high and `stall` is low. With no valid instruction neither is high. An instruction held in decode never stalls for more than the multiply latency minus one consecutive cycles.
- R12: For any stream of instructions in which decode holds its instruction while stalled, `stall`, `issue` and both selects match the per-class latency timing in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_cls | input | 2 | Operation class: 0 integer, 1 add/sub, 2 multiply, 3 load |
| dec_src_a | input | RW | First source register number |
| dec_src_b | input | RW | Second source register number |
| dec_dst | input | RW | Destination register number |
| dec_dst_en | input | 1 | Instruction writes `dec_dst` |
| stall | output | 1 | Hold fetch and decode this cycle |
| issue | output | 1 | Instruction leaves decode this cycle (low means bubble) |
| fwd_sel_a | output | 3 | Source of operand A: 0 register file, 1 integer, 2 add, 3 multiply, 4 memory |
| fwd_sel_b | output | 3 | Source of operand B, same encoding |

## Verification
Back-to-back producer and consumer pairs are run for each class, and the stall count is checked against a literal value. This separates the four latencies, and it separates the four path selects from one another. A consumer placed one cycle late tells a forwarding window that is too wide from one that is exact. Two staggered multiplies feeding one add show whether the stall waits for the last producer or the first. Register 0, a disabled destination and an overwritten destination each check that the block records only real, newest producers. A long random stream over eight registers, with decode held while stalled, is compared cycle by cycle against a reference model based on ready times.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_MEM = 2'd3
  } op_cls_e;

  typedef enum logic [2:0] {
    FWD_RF  = 3'd0,
    FWD_INT = 3'd1,
    FWD_ADD = 3'd2,
    FWD_MUL = 3'd3,
    FWD_MEM = 3'd4
  } fwd_src_e;

  function automatic fwd_src_e path_of(op_cls_e c);
    case (c)
      CLS_INT: path_of = FWD_INT;
      CLS_ADD: path_of = FWD_ADD;
      CLS_MUL: path_of = FWD_MUL;
      default: path_of = FWD_MEM;
    endcase
  endfunction

endpackage

// File: rtl/ilk_entry.sv
// One scoreboard slot: countdown to forwardability plus producing class.
module ilk_entry
  import ilk_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  op_cls_e       load_cls,
  output logic          live,
  output logic [CW-1:0] cnt,
  output op_cls_e       cls
);

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= 1'b0;
      cnt  <= '0;
      cls  <= CLS_INT;
    end else if (load) begin
      live <= 1'b1;
      cnt  <= load_cnt;
      cls  <= load_cls;
    end else if (live) begin
      // Final cycle of the forwarding window: value then sits in the file.
      if (cnt == '0) live <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/ilk_lookup.sv
// Per-operand lookup into the scoreboard.
module ilk_lookup
  import ilk_pkg::*;
#(
  parameter int NREG = 32,
  parameter int RW   = 5,
  parameter int CW   = 3
) (
  input  logic [RW-1:0] src,
  input  logic          live_i [NREG],
  input  logic [CW-1:0] cnt_i  [NREG],
  input  op_cls_e       cls_i  [NREG],
  output logic          busy,
  output fwd_src_e      sel
);

  logic hit;

  always_comb begin
    hit  = (src != '0) && live_i[src];
    busy = hit && (cnt_i[src] != '0);
    sel  = (hit && (cnt_i[src] == '0)) ? path_of(cls_i[src]) : FWD_RF;
  end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int INT_LAT = 1,
  parameter int ADD_LAT = 3,
  parameter int MUL_LAT = 5,
  parameter int MEM_LAT = 2,
  parameter int RW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [1:0]    dec_cls,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic [RW-1:0] dec_dst,
  input  logic          dec_dst_en,
  output logic          stall,
  output logic          issue,
  output logic [2:0]    fwd_sel_a,
  output logic [2:0]    fwd_sel_b
);

  localparam int MAX_AB = (ADD_LAT > INT_LAT) ? ADD_LAT : INT_LAT;
  localparam int MAX_CD = (MUL_LAT > MEM_LAT) ? MUL_LAT : MEM_LAT;
  localparam int MAXLAT = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = (MAXLAT > 2) ? $clog2(MAXLAT) : 1;

  op_cls_e cls_d;
  assign cls_d = op_cls_e'(dec_cls);

  function automatic logic [CW-1:0] span(op_cls_e c);
    case (c)
      CLS_INT: span = CW'(INT_LAT - 1);
      CLS_ADD: span = CW'(ADD_LAT - 1);
      CLS_MUL: span = CW'(MUL_LAT - 1);
      default: span = CW'(MEM_LAT - 1);
    endcase
  endfunction

  logic          sb_live [NREG];
  logic [CW-1:0] sb_cnt  [NREG];
  op_cls_e       sb_cls  [NREG];
  logic          records;
  logic [CW-1:0] new_cnt;

  assign records = issue && dec_dst_en && (dec_dst != '0);
  assign new_cnt = span(cls_d);

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_slot
      ilk_entry #(.CW(CW)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (records && (dec_dst == RW'(g))),
        .load_cnt (new_cnt),
        .load_cls (cls_d),
        .live     (sb_live[g]),
        .cnt      (sb_cnt[g]),
        .cls      (sb_cls[g])
      );
    end
  endgenerate

  logic     busy_op [2];
  fwd_src_e sel_op  [2];
  logic [RW-1:0] src_op [2];

  assign src_op[0] = dec_src_a;
  assign src_op[1] = dec_src_b;

  generate
    for (g = 0; g < 2; g++) begin : g_opnd
      ilk_lookup #(.NREG(NREG), .RW(RW), .CW(CW)) u_look (
        .src    (src_op[g]),
        .live_i (sb_live),
        .cnt_i  (sb_cnt),
        .cls_i  (sb_cls),
        .busy   (busy_op[g]),
        .sel    (sel_op[g])
      );
    end
  endgenerate

  assign stall     = dec_valid && (busy_op[0] || busy_op[1]);
  assign issue     = dec_valid && !stall;
  assign fwd_sel_a = 3'(sel_op[0]);
  assign fwd_sel_b = 3'(sel_op[1]);

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int RW      = 5,
  parameter int MUL_LAT = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_valid,
  input logic [1:0]    dec_cls,
  input logic [RW-1:0] dec_src_a,
  input logic [RW-1:0] dec_src_b,
  input logic [RW-1:0] dec_dst,
  input logic          dec_dst_en,
  input logic          stall,
  input logic          issue,
  input logic [2:0]    fwd_sel_a,
  input logic [2:0]    fwd_sel_b
);

  logic [7:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)        run_q <= '0;
    else if (stall) run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
    else            run_q <= '0;
  end

  // R2: a multiply result is not ready for the very next decode cycle
  p_mul_next_stalls_r2: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_dst_en && dec_dst != '0 && dec_cls == 2'd2)
    |=> (!(dec_valid && dec_src_a == $past(dec_dst)) || stall));

  // R5: integer result forwarded straight from its path next cycle
  p_int_next_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (issue && dec_dst_en && dec_dst != '0 && dec_cls == 2'd0)
    |=> (dec_src_a != $past(dec_dst) || fwd_sel_a == 3'd1));

  // R8: register 0 as both sources never stalls and reads the file
  p_zero_src_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_src_a == '0 && dec_src_b == '0)
    |-> (!stall && fwd_sel_a == 3'd0 && fwd_sel_b == 3'd0));

  // R11: no instruction, no stall and no issue
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!stall && !issue));

  // R11: consecutive stall cycles bounded by the longest latency
  p_stall_bound_r11: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run_q < 8'(MUL_LAT - 1)));

endmodule

bind issue_interlock ilk_checker #(.RW(RW), .MUL_LAT(MUL_LAT)) u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_cls(dec_cls),
  .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
  .dec_dst_en(dec_dst_en), .stall(stall), .issue(issue),
  .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
);

// File: tb/sim_issue_interlock.sv
`timescale 1ns/100ps
module sim_issue_interlock;

  localparam int NREG = 32;
  localparam int RW   = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dec_valid = 1'b0;
  logic [1:0]    dec_cls = 2'd0;
  logic [RW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic          dec_dst_en = 1'b0;
  logic          stall, issue;
  logic [2:0]    fwd_sel_a, fwd_sel_b;

  always #2.5 clk = ~clk;

  issue_interlock u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_cls(dec_cls),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
    .dec_dst_en(dec_dst_en), .stall(stall), .issue(issue),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // Reference model: cycle at which each register's result is forwardable.
  int rdy  [NREG];
  int pcls [NREG];
  int cyc = 0;
  bit exp_stall_q;

  function automatic int lat(int c);
    case (c)
      0: return 1;
      1: return 3;
      2: return 5;
      default: return 2;
    endcase
  endfunction

  function automatic bit m_busy(int s);
    return (s != 0) && (cyc < rdy[s]);
  endfunction

  function automatic int m_sel(int s);
    return ((s != 0) && (cyc == rdy[s])) ? pcls[s] + 1 : 0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NREG; i++) begin rdy[i] = -100; pcls[i] = 0; end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, int c, int a, int b, int d, bit de);
    bit es, ei;
    @(negedge clk);
    dec_valid = v; dec_cls = 2'(c); dec_src_a = RW'(a); dec_src_b = RW'(b);
    dec_dst = RW'(d); dec_dst_en = de;
    #1;
    es = v && (m_busy(a) || m_busy(b));
    ei = v && !es;
    chk(tag, "stall", int'(stall), int'(es));
    chk(tag, "issue", int'(issue), int'(ei));
    chk(tag, "fwd_sel_a", int'(fwd_sel_a), m_sel(a));
    chk(tag, "fwd_sel_b", int'(fwd_sel_b), m_sel(b));
    if (ei && de && d != 0) begin rdy[d] = cyc + lat(c); pcls[d] = c; end
    exp_stall_q = es;
    cyc++;
  endtask

  // Holds the instruction in decode until it issues; returns stall count.
  task automatic until_issue(string tag, int c, int a, int b, int d, bit de, output int n);
    n = 0;
    step(tag, 1, c, a, b, d, de);
    while (exp_stall_q && n < 20) begin
      n++;
      step(tag, 1, c, a, b, d, de);
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step("R11", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; dec_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    model_clear();
    do_reset();

    // R1: fresh state, sources with nonzero numbers issue at once
    until_issue("R1", 2, 7, 9, 3, 1, n);
    chk("R1", "stall count", n, 0);
    idle(6);

    // R2: multiply then dependent
    step("R2", 1, 2, 1, 2, 4, 1);
    until_issue("R2", 1, 4, 0, 5, 1, n);
    chk("R2", "stall count", n, 4);
    idle(6);

    // R3: add then dependent
    step("R3", 1, 1, 1, 2, 6, 1);
    until_issue("R3", 0, 0, 6, 7, 1, n);
    chk("R3", "stall count", n, 2);
    idle(6);

    // R4: load then dependent add
    step("R4", 1, 3, 1, 0, 8, 1);
    until_issue("R4", 1, 4, 8, 9, 1, n);
    chk("R4", "stall count", n, 1);
    idle(6);

    // R5: integer then dependent
    step("R5", 1, 0, 1, 2, 10, 1);
    until_issue("R5", 0, 10, 10, 11, 1, n);
    chk("R5", "stall count", n, 0);
    idle(6);

    // R6: two multiplies feeding one add; wait for the later
    step("R6", 1, 2, 2, 2, 6, 1);
    step("R6", 1, 2, 4, 4, 8, 1);
    until_issue("R6", 1, 6, 8, 10, 1, n);
    chk("R6", "stall count", n, 4);
    idle(6);

    // R7: consumer one cycle past the window reads the file
    step("R7", 1, 1, 1, 2, 12, 1);
    idle(3);
    until_issue("R7", 0, 12, 0, 13, 1, n);
    chk("R7", "stall count", n, 0);
    idle(6);

    // R8: register 0 as destination then as source
    step("R8", 1, 2, 1, 2, 0, 1);
    until_issue("R8", 0, 0, 0, 14, 1, n);
    chk("R8", "stall count", n, 0);
    idle(6);

    // R9: destination disabled
    step("R9", 1, 2, 1, 2, 15, 0);
    until_issue("R9", 0, 15, 15, 16, 1, n);
    chk("R9", "stall count", n, 0);
    idle(6);

    // R10: newer integer writer replaces older multiply
    step("R10", 1, 2, 1, 2, 17, 1);
    step("R10", 1, 0, 1, 2, 17, 1);
    until_issue("R10", 0, 17, 0, 18, 1, n);
    chk("R10", "stall count", n, 0);
    idle(6);

    // R1: reset discards pending dependence
    step("R1", 1, 2, 1, 2, 19, 1);
    do_reset();
    until_issue("R1", 0, 19, 0, 20, 1, n);
    chk("R1", "stall count", n, 0);
    idle(6);

    // R12: random stream with decode held while stalled
    begin
      int c = 0, a = 0, b = 0, d = 0;
      bit v = 0, de = 0;
      for (int i = 0; i < 2000; i++) begin
        if (!exp_stall_q) begin
          v  = ($urandom_range(0, 9) < 8);
          c  = $urandom_range(0, 3);
          a  = $urandom_range(0, 7);
          b  = $urandom_range(0, 7);
          d  = $urandom_range(0, 7);
          de = ($urandom_range(0, 5) != 0);
        end
        step("R12", v, c, a, b, d, de);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule